// File: doc/BRIEF.md
# Shift-Add Product Register

This block holds the partial product and the multiplier of a serial shift-and-add multiplier in one word. The low field takes the multiplier operand. The high field takes the adder result, which is the partial sum together with its carry. A shift strobe moves the whole word one place to the right. Over repeated add and shift steps, the product forms in the word while the multiplier bits leave at the bottom. The adder and the sequencer sit outside this block.

Everything runs on one system clock with a synchronous active-high reset. The two load strobes come from the same clock domain and are sampled directly. The shift strobe may come from elsewhere. It passes through a synchroniser and a rising-edge detector, so each pulse yields exactly one shift. With the default two synchroniser stages, the word shifts on the third rising clock edge that samples the strobe high. With the default widths the word is 9 bits: a 4-bit low field at bits 3..0 and a 5-bit high field at bits 8..4. Bit 0 is brought out alone as the serial LSB, and bits 8..1 form the upper output.

Top module: `prod_shift_reg`

## Requirements
- R1: While `rst` is high at a clock edge the word becomes all zeros, even if a load strobe is also high; the outputs read zero after reset.
- R2: `load_mult` high at a clock edge writes `mult_in` into word bits 3..0 and leaves bits 8..4 unchanged.
- R3: `load_sum` high at a clock edge writes `sum_in` into word bits 8..4 and leaves bits 3..0 unchanged.
- R4: With both load strobes high at the same edge, both fields are written in that edge.
- R5: A rising edge of `shift_strobe` shifts the word right by one place, and a zero enters bit 8. With two synchroniser stages the change appears after the third clock edge that samples the strobe high, and not before.
- R6: A `shift_strobe` held high for many cycles produces only one shift.
- R7: If a detected shift falls in the same cycle as a load, the load is applied and that shift is discarded.
- R8: Without load, reset or strobe edges the word holds its value, and after 9 shifts with no loads the word is all zeros.
- R9: `prod_lsb` presents word bit 0 and `prod_hi` presents word bits 8..1; loading 9 and 7 gives word 0_0111_1001 and one shift gives 0_0011_1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mult_in | input | 4 | Multiplier operand for the low field |
| sum_in | input | 5 | Adder sum with carry for the high field |
| load_mult | input | 1 | Load strobe for the low field |
| load_sum | input | 1 | Load strobe for the high field |
| shift_strobe | input | 1 | Shift request; each rising edge gives one shift |
| prod_hi | output | 8 | Word bits 8..1 |
| prod_lsb | output | 1 | Word bit 0 |

## Verification
On every cycle, the assertions check four things. The word is zero after reset. Each load writes its own field and leaves the other field alone. In a cycle with no load, the word either holds or moves right by one place with a zero at the top. The scenarios cover what those per-cycle checks cannot show. They pin down the exact three-edge latency of the synchronised strobe and show that a long strobe gives only one shift. They also show that a shift colliding with a load is lost rather than delayed, and that nine shifts drain a full word.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic shift;
  } psr_ctrl_t;
endpackage

// File: rtl/psr_strobe_edge.sv
module psr_strobe_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic pulse
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign pulse = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/psr_op_select.sv
module psr_op_select
  import psr_pkg::*;
(
  input  logic      load_lo,
  input  logic      load_hi,
  input  logic      shift_pulse,
  output psr_ctrl_t ctrl
);
  always_comb begin
    ctrl.ld_lo = load_lo;
    ctrl.ld_hi = load_hi;
    ctrl.shift = shift_pulse & ~load_lo & ~load_hi;
  end
endmodule

// File: rtl/psr_word.sv
module psr_word
  import psr_pkg::*;
#(
  parameter int LO_W = 4,
  parameter int HI_W = 5,
  localparam int W = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  psr_ctrl_t       ctrl,
  input  logic [LO_W-1:0] lo_in,
  input  logic [HI_W-1:0] hi_in,
  output logic [W-1:0]    word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (ctrl.ld_lo || ctrl.ld_hi) begin
      if (ctrl.ld_lo) word[LO_W-1:0] <= lo_in;
      if (ctrl.ld_hi) word[W-1:LO_W] <= hi_in;
    end else if (ctrl.shift) begin
      word <= {1'b0, word[W-1:1]};
    end
  end
endmodule

// File: rtl/prod_shift_reg.sv
module prod_shift_reg
  import psr_pkg::*;
#(
  parameter int MULT_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SUM_W = MULT_W + 1,
  localparam int REG_W = MULT_W + SUM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [SUM_W-1:0]  sum_in,
  input  logic              load_mult,
  input  logic              load_sum,
  input  logic              shift_strobe,
  output logic [REG_W-1:1]  prod_hi,
  output logic              prod_lsb
);
  logic           shift_pulse;
  psr_ctrl_t      ctrl;
  logic [REG_W-1:0] word;

  psr_strobe_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(shift_strobe), .pulse(shift_pulse)
  );

  psr_op_select u_sel (
    .load_lo(load_mult), .load_hi(load_sum),
    .shift_pulse(shift_pulse), .ctrl(ctrl)
  );

  psr_word #(.LO_W(MULT_W), .HI_W(SUM_W)) u_word (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .lo_in(mult_in), .hi_in(sum_in), .word(word)
  );

  assign prod_hi  = word[REG_W-1:1];
  assign prod_lsb = word[0];
endmodule

// File: rtl/prod_shift_reg_chk.sv
module prod_shift_reg_chk #(
  parameter int MULT_W = 4,
  localparam int SUM_W = MULT_W + 1,
  localparam int REG_W = MULT_W + SUM_W
) (
  input logic              clk,
  input logic              rst,
  input logic [MULT_W-1:0] mult_in,
  input logic [SUM_W-1:0]  sum_in,
  input logic              load_mult,
  input logic              load_sum,
  input logic [REG_W-1:1]  prod_hi,
  input logic              prod_lsb
);
  logic [REG_W-1:0] w;
  assign w = {prod_hi, prod_lsb};

  // R1
  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (w == '0));

  // R2
  assert_low_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_mult)) |-> (w[MULT_W-1:0] == $past(mult_in)));

  assert_low_load_keeps_high_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_mult) && !$past(load_sum))
      |-> (w[REG_W-1:MULT_W] == $past(w[REG_W-1:MULT_W])));

  // R3
  assert_high_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_sum)) |-> (w[REG_W-1:MULT_W] == $past(sum_in)));

  assert_high_load_keeps_low_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_sum) && !$past(load_mult))
      |-> (w[MULT_W-1:0] == $past(w[MULT_W-1:0])));

  // R5
  assert_hold_or_shift_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_mult) && !$past(load_sum))
      |-> ((w == $past(w)) || (w == ($past(w) >> 1))));
endmodule

bind prod_shift_reg prod_shift_reg_chk #(.MULT_W(MULT_W)) u_chk (
  .clk(clk), .rst(rst), .mult_in(mult_in), .sum_in(sum_in),
  .load_mult(load_mult), .load_sum(load_sum),
  .prod_hi(prod_hi), .prod_lsb(prod_lsb)
);

// File: tb/prod_shift_reg_bench.sv
module prod_shift_reg_bench;
  localparam int MW = 4;
  localparam int SW = MW + 1;
  localparam int RW = MW + SW;

  typedef struct {
    logic [RW-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [MW-1:0] mult_in = '0;
  logic [SW-1:0] sum_in = '0;
  logic          load_mult = 1'b0;
  logic          load_sum = 1'b0;
  logic          shift_strobe = 1'b0;
  logic [RW-1:1] prod_hi;
  logic          prod_lsb;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  item_t q[$];
  event check_ev;
  logic [RW-1:0] model = '0;

  prod_shift_reg u_prod_shift_reg (
    .clk(clk), .rst(rst), .mult_in(mult_in), .sum_in(sum_in),
    .load_mult(load_mult), .load_sum(load_sum), .shift_strobe(shift_strobe),
    .prod_hi(prod_hi), .prod_lsb(prod_lsb)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      @(check_ev);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if ({prod_hi, prod_lsb} !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=%b expected=%b", it.tag,
                   {prod_hi, prod_lsb}, it.exp);
        end
      end
    end
  end

  task automatic expect_now(input logic [RW-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
    ->check_ev;
    #0;
  endtask

  task automatic do_load(input bit lm, input bit ls,
                         input logic [MW-1:0] mi, input logic [SW-1:0] si);
    @(negedge clk);
    load_mult = lm; load_sum = ls; mult_in = mi; sum_in = si;
    @(negedge clk);
    load_mult = 1'b0; load_sum = 1'b0;
    if (lm) model[MW-1:0] = mi;
    if (ls) model[RW-1:MW] = si;
  endtask

  task automatic do_shift(input int hold);
    @(negedge clk);
    shift_strobe = 1'b1;
    repeat (hold) @(negedge clk);
    shift_strobe = 1'b0;
    repeat (3) @(negedge clk);
    model = model >> 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_now('0, "R1 reset state");
    rst = 1'b0;

    // R9 example and R2/R3 field loads
    do_load(1, 0, 4'd9, '0);
    expect_now(model, "R2 low load");
    do_load(0, 1, '0, 5'd7);
    expect_now(model, "R3 high load");
    expect_now(9'b0_0111_1001, "R9 example load");
    do_shift(1);
    expect_now(9'b0_0011_1100, "R9 example shift");
    expect_now(model, "R5 one shift");

    // R2 keeps high field, R3 keeps low field
    do_load(1, 0, 4'd6, '0);
    expect_now(model, "R2 high kept");
    do_load(0, 1, '0, 5'h1A);
    expect_now(model, "R3 low kept");

    // R4 both loads at once
    do_load(1, 1, 4'h5, 5'h13);
    expect_now(model, "R4 dual load");

    // R5 latency: no change after two edges, change after third
    @(negedge clk);
    shift_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expect_now(model, "R5 not yet shifted");
    @(negedge clk);
    model = model >> 1;
    expect_now(model, "R5 shifted on third edge");
    // R6 held strobe: no further shift
    repeat (8) @(negedge clk);
    expect_now(model, "R6 held strobe single shift");
    shift_strobe = 1'b0;
    repeat (4) @(negedge clk);
    expect_now(model, "R8 idle hold");

    // R7 load collides with detected shift
    @(negedge clk);
    shift_strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load_sum = 1'b1; sum_in = 5'h0B;
    @(negedge clk);
    load_sum = 1'b0; shift_strobe = 1'b0;
    model[RW-1:MW] = 5'h0B;
    expect_now(model, "R7 load wins");
    repeat (5) @(negedge clk);
    expect_now(model, "R7 shift discarded");

    // R8 drain a full word
    do_load(1, 1, 4'hF, 5'h1F);
    expect_now(9'h1FF, "R8 full load");
    for (int k = 0; k < RW; k++) begin
      do_shift(2);
      expect_now(model, "R5 drain step");
    end
    expect_now('0, "R8 drained to zero");

    // R1 reset beats load
    do_load(1, 1, 4'h3, 5'h11);
    @(negedge clk);
    rst = 1'b1; load_mult = 1'b1; mult_in = 4'hA;
    @(negedge clk);
    rst = 1'b0; load_mult = 1'b0;
    model = '0;
    expect_now(model, "R1 reset over load");

    #1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule